// File: doc/BRIEF.md
# Pipelined System Bus Master Interface

This block lets a processor-side client start single transfers on a pipelined system bus on which it acts as master. A request carries an address, a write flag, a byte/word size, write data and a lock flag. It enters through a valid/ready port. The block then presents the transfer attributes on the bus one cycle ahead of the data phase. It waits until it owns the bus, and it completes the transfer according to three slave responses: wait, error and last. A single-cycle response pulse returns the read data and an error flag.

The request port applies back-pressure. `req_ready` is high only when no transfer is in flight, and a request is taken on a clock edge where `req_valid` and `req_ready` are both high. The response is a one-cycle strobe with no back-pressure. The client must take it in the cycle it is shown.

When a slave reports error and last together, the transfer is retracted. The block reports nothing and issues the same transfer again. When last is high at completion, the next transfer must not follow as a burst continuation, so the block inserts one idle decode cycle before it takes a new request. All outputs come from registers on the rising edge of `clk`. `rst_n` is an active-low reset.

Top module: `sysbus_master`

## Requirements
- R1: After reset, `bus_trans` is 00 (address-only), `bus_lock`, `bus_wdata_en` and `rsp_valid` are 0, and `req_ready` is 1.
- R2: `bus_req` is always 1 and `bus_prot` is always 01 (privileged data access).
- R3: In the cycle after a request is accepted, `bus_trans` is 11 (sequential), and `bus_addr`, `bus_write` and `bus_size` carry the request (size 10 for word, 00 for byte). `req_ready` stays 0 and the presented attributes ignore `req_*` changes until the transfer is finished.
- R4: The block stays in the address phase (`bus_trans` 11, `bus_wdata_en` 0) until an edge with `bus_grant` 1 and `bus_wait` 0. In the data phase that follows, `bus_trans` is 00 and `bus_wdata_en` equals the write flag, with `bus_wdata` holding the write data.
- R5: While `bus_wait` is 1 in the data phase, the transfer does not complete and `bus_addr`, `bus_write` and `bus_size` stay stable.
- R6: A data-phase edge with `bus_wait` 0 and not both `bus_error` and `bus_last` completes the transfer. In the next cycle `rsp_valid` is 1 for exactly one cycle, `rsp_error` equals the sampled `bus_error`, `rsp_rdata` equals the sampled `bus_rdata`, and `bus_wdata_en` is 0.
- R7: A data-phase edge with `bus_wait` 0, `bus_error` 1 and `bus_last` 1 is a retract. No response is given, the block returns to the address phase (`bus_trans` 11) with the same attributes, and it completes the transfer later.
- R8: After a completion with `bus_last` 1, `req_ready` is 0 for exactly one cycle and then returns to 1. After a completion with `bus_last` 0, `req_ready` is 1 in the next cycle.
- R9: `bus_lock` takes the request's lock flag at acceptance and keeps it, including across idle cycles, until the next accepted request.
- R10: `bus_trans` only ever shows 00 or 11 (10, non-sequential, is never issued), and `bus_size` only ever shows 00 or 10.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | ADDR_W | Transfer address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_lock | input | 1 | Request locked bus ownership |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle completion strobe |
| rsp_error | output | 1 | Completed transfer failed |
| rsp_rdata | output | DATA_W | Read data of completed transfer |
| bus_req | output | 1 | Bus request, always high |
| bus_grant | input | 1 | Grant from arbiter |
| bus_addr | output | ADDR_W | Bus address |
| bus_write | output | 1 | Bus direction |
| bus_size | output | 2 | Transfer size code |
| bus_trans | output | 2 | Transfer type code |
| bus_prot | output | 2 | Protection code, fixed 01 |
| bus_lock | output | 1 | Indivisible-sequence request |
| bus_wdata | output | DATA_W | Write data toward the shared data bus |
| bus_wdata_en | output | 1 | Drive enable for the shared data bus |
| bus_rdata | input | DATA_W | Data from the shared data bus |
| bus_wait | input | 1 | Slave needs more cycles |
| bus_error | input | 1 | Slave error response |
| bus_last | input | 1 | Slave last/no-burst response |

## Verification
The main function is exercised with a zero-wait word write, a byte read held by several wait cycles, a write whose grant is withheld and then offered while wait is still high, an error completion and a retract. Together these separate the ownership rule (grant alone is not enough) from the completion rule, and a retract from an error completion. Completions with last high and with last low show whether the decode gap is inserted only when required. A locked transfer followed by an unlocked one shows whether the lock persists over idle cycles and is released only at the next acceptance.

// File: rtl/sbm_pkg.sv
package sbm_pkg;
  typedef enum logic [1:0] {
    PH_IDLE = 2'd0,
    PH_ADDR = 2'd1,
    PH_DATA = 2'd2,
    PH_GAP  = 2'd3
  } phase_e;

  localparam logic [1:0] TRN_ADDR_ONLY = 2'b00;
  localparam logic [1:0] TRN_NONSEQ    = 2'b10;
  localparam logic [1:0] TRN_SEQ       = 2'b11;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_WORD = 2'b10;

  localparam logic [1:0] PROT_PRIV_DATA = 2'b01;
endpackage

// File: rtl/sbm_hold.sv
module sbm_hold #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              in_write,
  input  logic              in_word,
  input  logic              in_lock,
  input  logic [DATA_W-1:0] in_wdata,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_write,
  output logic [1:0]        out_size,
  output logic              out_lock,
  output logic [DATA_W-1:0] out_wdata
);
  import sbm_pkg::*;

  // Attribute registers only change at acceptance, so they stay
  // stable through wait states and retracts.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_addr  <= '0;
      out_write <= 1'b0;
      out_size  <= SZ_BYTE;
      out_lock  <= 1'b0;
      out_wdata <= '0;
    end else if (load) begin
      out_addr  <= in_addr;
      out_write <= in_write;
      out_size  <= in_word ? SZ_WORD : SZ_BYTE;
      out_lock  <= in_lock;
      out_wdata <= in_wdata;
    end
  end
endmodule

// File: rtl/sbm_ctrl.sv
module sbm_ctrl (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  input  logic           held_write,
  input  logic           grant,
  input  logic           slv_wait,
  input  logic           slv_error,
  input  logic           slv_last,
  output logic           req_ready,
  output logic           load,
  output logic           complete,
  output logic [1:0]     trans,
  output logic           wdata_en,
  output sbm_pkg::phase_e phase
);
  import sbm_pkg::*;

  phase_e nxt;
  logic   retract;

  assign req_ready = (phase == PH_IDLE);
  assign load      = req_ready && req_valid;
  assign retract   = (phase == PH_DATA) && !slv_wait && slv_error && slv_last;
  assign complete  = (phase == PH_DATA) && !slv_wait && !(slv_error && slv_last);

  always_comb begin
    nxt = phase;
    unique case (phase)
      PH_IDLE: if (load) nxt = PH_ADDR;
      PH_ADDR: if (grant && !slv_wait) nxt = PH_DATA;
      PH_DATA: begin
        if (retract)       nxt = PH_ADDR;
        else if (complete) nxt = slv_last ? PH_GAP : PH_IDLE;
      end
      PH_GAP:  nxt = PH_IDLE;
      default: nxt = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= PH_IDLE;
      trans    <= TRN_ADDR_ONLY;
      wdata_en <= 1'b0;
    end else begin
      phase    <= nxt;
      trans    <= (nxt == PH_ADDR) ? TRN_SEQ : TRN_ADDR_ONLY;
      wdata_en <= (nxt == PH_DATA) && held_write;
    end
  end
endmodule

// File: rtl/sbm_resp.sv
module sbm_resp #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              complete,
  input  logic              slv_error,
  input  logic [DATA_W-1:0] slv_rdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= complete;
      rsp_error <= complete && slv_error;
      if (complete) rsp_rdata <= slv_rdata;
    end
  end
endmodule

// File: rtl/sysbus_master.sv
module sysbus_master #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_write,
  input  logic              req_word,
  input  logic              req_lock,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              bus_req,
  input  logic              bus_grant,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_write,
  output logic [1:0]        bus_size,
  output logic [1:0]        bus_trans,
  output logic [1:0]        bus_prot,
  output logic              bus_lock,
  output logic [DATA_W-1:0] bus_wdata,
  output logic              bus_wdata_en,
  input  logic [DATA_W-1:0] bus_rdata,
  input  logic              bus_wait,
  input  logic              bus_error,
  input  logic              bus_last
);
  import sbm_pkg::*;

  logic   load;
  logic   complete;
  phase_e phase;

  assign bus_req  = 1'b1;
  assign bus_prot = PROT_PRIV_DATA;

  sbm_hold #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .in_addr   (req_addr),
    .in_write  (req_write),
    .in_word   (req_word),
    .in_lock   (req_lock),
    .in_wdata  (req_wdata),
    .out_addr  (bus_addr),
    .out_write (bus_write),
    .out_size  (bus_size),
    .out_lock  (bus_lock),
    .out_wdata (bus_wdata)
  );

  sbm_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .held_write (bus_write),
    .grant      (bus_grant),
    .slv_wait   (bus_wait),
    .slv_error  (bus_error),
    .slv_last   (bus_last),
    .req_ready  (req_ready),
    .load       (load),
    .complete   (complete),
    .trans      (bus_trans),
    .wdata_en   (bus_wdata_en),
    .phase      (phase)
  );

  sbm_resp #(.DATA_W(DATA_W)) u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .complete  (complete),
    .slv_error (bus_error),
    .slv_rdata (bus_rdata),
    .rsp_valid (rsp_valid),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata)
  );
endmodule

// File: rtl/sbm_checker.sv
module sbm_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input sbm_pkg::phase_e   phase,
  input logic              req_valid,
  input logic              req_ready,
  input logic              rsp_valid,
  input logic              bus_req,
  input logic [1:0]        bus_prot,
  input logic [1:0]        bus_trans,
  input logic [1:0]        bus_size,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_write,
  input logic              bus_lock,
  input logic              bus_wdata_en,
  input logic              bus_wait,
  input logic              bus_error,
  input logic              bus_last
);
  import sbm_pkg::*;

  p_fixed_lines_r2: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req && (bus_prot == 2'b01));

  p_codes_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((bus_trans == 2'b00) || (bus_trans == 2'b11)) &&
    ((bus_size == 2'b00) || (bus_size == 2'b10)));

  p_data_drive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    bus_wdata_en |-> (bus_write && (bus_trans == 2'b00)));

  p_hold_stable_r5: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DATA) && bus_wait) |=>
      ($stable(bus_addr) && $stable(bus_write) && $stable(bus_size)));

  p_rsp_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  p_retract_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DATA) && !bus_wait && bus_error && bus_last) |=>
      (!rsp_valid && (bus_trans == 2'b11)));

  p_decode_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((phase == PH_DATA) && !bus_wait && bus_last && !bus_error) |=> !req_ready);

  p_lock_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && req_ready) |=> $stable(bus_lock));
endmodule

bind sysbus_master sbm_checker #(.ADDR_W(ADDR_W)) u_sbm_checker (
  .clk          (clk),
  .rst_n        (rst_n),
  .phase        (phase),
  .req_valid    (req_valid),
  .req_ready    (req_ready),
  .rsp_valid    (rsp_valid),
  .bus_req      (bus_req),
  .bus_prot     (bus_prot),
  .bus_trans    (bus_trans),
  .bus_size     (bus_size),
  .bus_addr     (bus_addr),
  .bus_write    (bus_write),
  .bus_lock     (bus_lock),
  .bus_wdata_en (bus_wdata_en),
  .bus_wait     (bus_wait),
  .bus_error    (bus_error),
  .bus_last     (bus_last)
);

// File: tb/test_sysbus_master.sv
module test_sysbus_master;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic [AW-1:0] req_addr = '0;
  logic          req_write = 1'b0;
  logic          req_word = 1'b0;
  logic          req_lock = 1'b0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_valid;
  logic          rsp_error;
  logic [DW-1:0] rsp_rdata;
  logic          bus_req;
  logic          bus_grant = 1'b1;
  logic [AW-1:0] bus_addr;
  logic          bus_write;
  logic [1:0]    bus_size;
  logic [1:0]    bus_trans;
  logic [1:0]    bus_prot;
  logic          bus_lock;
  logic [DW-1:0] bus_wdata;
  logic          bus_wdata_en;
  logic [DW-1:0] bus_rdata = '0;
  logic          bus_wait = 1'b0;
  logic          bus_error = 1'b0;
  logic          bus_last = 1'b0;

  int  n_tests = 0;
  int  n_fail = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sysbus_master #(.ADDR_W(AW), .DATA_W(DW)) i_sysbus_master (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_write(req_write), .req_word(req_word), .req_lock(req_lock),
    .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .bus_req(bus_req), .bus_grant(bus_grant), .bus_addr(bus_addr),
    .bus_write(bus_write), .bus_size(bus_size), .bus_trans(bus_trans),
    .bus_prot(bus_prot), .bus_lock(bus_lock), .bus_wdata(bus_wdata),
    .bus_wdata_en(bus_wdata_en), .bus_rdata(bus_rdata), .bus_wait(bus_wait),
    .bus_error(bus_error), .bus_last(bus_last)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Offer a request in IDLE; returns at the negedge after acceptance.
  task automatic accept(input logic [AW-1:0] a, input logic w, input logic wd,
                        input logic lk, input logic [DW-1:0] d);
    req_addr = a; req_write = w; req_word = wd; req_lock = lk; req_wdata = d;
    req_valid = 1'b1;
    step();
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    check("R1 trans", bus_trans, 2'b00);
    check("R1 lock", bus_lock, 0);
    check("R1 wdata_en", bus_wdata_en, 0);
    check("R1 rsp_valid", rsp_valid, 0);
    check("R1 ready", req_ready, 1);
    check("R2 req", bus_req, 1);
    check("R2 prot", bus_prot, 2'b01);
  endtask

  task automatic t_write_nowait();
    accept(32'h0000_1000, 1'b1, 1'b1, 1'b0, 32'hCAFE_0001);
    check("R3 trans seq", bus_trans, 2'b11);
    check("R3 addr", bus_addr, 32'h0000_1000);
    check("R3 write", bus_write, 1);
    check("R3 size word", bus_size, 2'b10);
    check("R3 ready low", req_ready, 0);
    step();
    check("R4 trans data", bus_trans, 2'b00);
    check("R4 wdata_en", bus_wdata_en, 1);
    check("R4 wdata", bus_wdata, 32'hCAFE_0001);
    step();
    check("R6 rsp_valid", rsp_valid, 1);
    check("R6 rsp_error", rsp_error, 0);
    check("R6 wdata_en off", bus_wdata_en, 0);
    check("R8 ready after last low", req_ready, 1);
    step();
    check("R6 single pulse", rsp_valid, 0);
  endtask

  task automatic t_read_waits();
    accept(32'h0000_2003, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R3 size byte", bus_size, 2'b00);
    step();
    bus_wait = 1'b1;
    for (int i = 0; i < 3; i++) begin
      step();
      check("R5 no completion", rsp_valid, 0);
      check("R5 addr stable", bus_addr, 32'h0000_2003);
      check("R5 size stable", bus_size, 2'b00);
      check("R4 read no drive", bus_wdata_en, 0);
    end
    bus_wait = 1'b0; bus_rdata = 32'h1234_ABCD;
    step();
    bus_rdata = 32'h0;
    check("R6 read valid", rsp_valid, 1);
    check("R6 rdata", rsp_rdata, 32'h1234_ABCD);
    step();
  endtask

  task automatic t_grant();
    accept(32'h0000_3000, 1'b1, 1'b1, 1'b0, 32'h5555_AAAA);
    bus_grant = 1'b0;
    req_valid = 1'b1; req_addr = 32'hDEAD_0000; req_write = 1'b0;
    step();
    check("R4 no grant trans", bus_trans, 2'b11);
    check("R4 no grant drive", bus_wdata_en, 0);
    check("R3 busy ignores addr", bus_addr, 32'h0000_3000);
    check("R3 busy ignores write", bus_write, 1);
    req_valid = 1'b0;
    bus_grant = 1'b1; bus_wait = 1'b1;
    step();
    check("R4 grant with wait", bus_trans, 2'b11);
    check("R4 grant with wait drive", bus_wdata_en, 0);
    bus_wait = 1'b0;
    step();
    check("R4 owned drive", bus_wdata_en, 1);
    check("R4 owned wdata", bus_wdata, 32'h5555_AAAA);
    step();
    check("R6 grant test done", rsp_valid, 1);
    step();
  endtask

  task automatic t_error();
    accept(32'h0000_4000, 1'b0, 1'b1, 1'b0, 32'h0);
    step();
    bus_error = 1'b1;
    step();
    bus_error = 1'b0;
    check("R6 error valid", rsp_valid, 1);
    check("R6 error flag", rsp_error, 1);
    step();
  endtask

  task automatic t_retract();
    accept(32'h0000_5000, 1'b1, 1'b1, 1'b0, 32'h7777_0000);
    step();
    bus_error = 1'b1; bus_last = 1'b1;
    step();
    bus_error = 1'b0; bus_last = 1'b0;
    check("R7 no response", rsp_valid, 0);
    check("R7 reissue trans", bus_trans, 2'b11);
    check("R7 same addr", bus_addr, 32'h0000_5000);
    check("R7 drive off", bus_wdata_en, 0);
    check("R7 ready low", req_ready, 0);
    step();
    check("R7 second data phase", bus_wdata_en, 1);
    step();
    check("R7 completes later", rsp_valid, 1);
    check("R7 clean error", rsp_error, 0);
    step();
  endtask

  task automatic t_last_gap();
    accept(32'h0000_6000, 1'b0, 1'b1, 1'b0, 32'h0);
    step();
    bus_last = 1'b1;
    step();
    bus_last = 1'b0;
    check("R8 completes", rsp_valid, 1);
    check("R8 gap ready low", req_ready, 0);
    step();
    check("R8 ready back", req_ready, 1);
    check("R8 idle trans", bus_trans, 2'b00);
  endtask

  task automatic t_lock();
    accept(32'h0000_7000, 1'b1, 1'b1, 1'b1, 32'h1);
    check("R9 lock set", bus_lock, 1);
    step(); step();
    step(); step();
    check("R9 lock held idle", bus_lock, 1);
    accept(32'h0000_7004, 1'b1, 1'b1, 1'b1, 32'h2);
    check("R9 lock second", bus_lock, 1);
    step(); step();
    accept(32'h0000_7008, 1'b0, 1'b0, 1'b0, 32'h0);
    check("R9 lock released", bus_lock, 0);
    step(); step(); step();
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_write_nowait();
    t_read_waits();
    t_grant();
    t_error();
    t_retract();
    t_last_gap();
    t_lock();
    check("R2 prot end", bus_prot, 2'b01);
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!finished) begin
      finished = 1'b1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule